// File: doc/BRIEF.md
# Wired Interrupt Aggregator

The aggregator gathers a parameterised set of interrupt request lines (32 by default) into a single wired request for a parent interrupt controller. Each line first crosses a two-stage synchroniser. A per-line pending bit then records the request. The block compares the pending bits with a per-line block mask and drives the registered output high whenever any pending line is not blocked.

Software talks to the block through a 32-bit register port that completes in one cycle. The port has a strobe, a write flag, an address and write data, and it returns read data that is registered. Through it software reads the raw pending bits, clears pending bits by writing zeros, injects pending bits to retrigger a line, programs the block mask, and picks one sense mode for the whole instance: either every line is sensed as level-high or every line is captured on a rising edge. The control word also stores one extra bit, a mask flag for message-signalled delivery. That bit is only kept and read back.

Top module: `irq_wire_agg`

## Requirements
- R1: After a synchronous reset, the pending register reads 0x00000000, the block mask reads 0xFFFFFFFF, the control word reads 0x00000000 and `irq_o` is 0.
- R2: With control bit 3 clear (level mode), a pending bit is set on every cycle its synchronised line is high. Writing 0 to that bit while the line stays high has no lasting effect.
- R3: With control bit 3 set (edge mode), a pending bit is set only on a 0-to-1 transition of its synchronised line and stays set after the line falls. After it is cleared, a line held high does not set it again. A line pulse one cycle wide is still captured.
- R4: A write to offset 0x00 clears every pending bit whose write-data bit is 0 and leaves pending bits whose write-data bit is 1 unchanged.
- R5: A write to offset 0x08 sets every pending bit whose write-data bit is 1, and data bits of 0 have no effect. A read of 0x08 returns zero.
- R6: Offset 0x10 holds the block mask and reads back what was written. A mask bit of 1 keeps its pending line off `irq_o`.
- R7: `irq_o` equals the OR over all lines of (pending AND NOT mask) as it stood one clock earlier.
- R8: A read of offset 0x00 returns the raw pending bits, whatever the mask holds.
- R9: Offset 0x28 stores only bit 3 (edge mode) and bit 5 (message-signalled mask flag). All other bits read 0, and bit 5 does not affect pending capture or `irq_o`.
- R10: When a hardware set and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R11: Read data appears on `bus_rdata` after the clock edge that samples a read strobe and holds until the next read. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous interrupt request lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Registered wired interrupt to the parent controller |

## Verification
The assertions check four things on every cycle. A hardware set is never lost to a clear in the same cycle. Injected bits always land. Cleared bits drop unless something re-sets them. No pending bit rises without a cause. On top of that, edge mode gives single-cycle set pulses, the output tracks pending-and-unmasked with one cycle of delay, and mask and pending reads return the right values. Only the bench's sweeps can show the rest: level-mode persistence against clears, latching of short pulses in edge mode, the exact timing of a clear that collides with a rising edge, reserved control bits reading zero, and the mask isolating each line from its neighbours.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Byte offsets of the register port
  localparam logic [7:0] OFF_PEND = 8'h00;
  localparam logic [7:0] OFF_INJ  = 8'h08;
  localparam logic [7:0] OFF_BLK  = 8'h10;
  localparam logic [7:0] OFF_CTL  = 8'h28;

  // Control word bit positions
  localparam int CTL_EDGE_BIT = 3;
  localparam int CTL_MSG_BIT  = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_INJ,
    SEL_BLK,
    SEL_CTL
  } reg_sel_e;
endpackage

// File: rtl/irq_src_front.sv
module irq_src_front #(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               edge_mode,
  output logic [NUM_SRC-1:0] hw_set_o
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], src_i[g]};
        prev_q <= synced;
      end
    end

    assign synced      = sync_q[TOP];
    assign hw_set_o[g] = edge_mode ? (synced & ~prev_q) : synced;

    // R3: in edge mode a set request lasts a single cycle
    p_edge_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      (edge_mode && hw_set_o[g]) |=> (!edge_mode || !hw_set_o[g]));
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_keep,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] pend_d;

  // Sets are ORed in after the clear, so a set always wins
  always_comb pend_d = (pend_q & sw_keep) | sw_set | hw_set;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R10: a hardware set is never lost
  p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

  // R5: an injected bit always lands
  p_inject_lands_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(sw_set)) == $past(sw_set)));

  // R4: a cleared bit with no set in the same cycle drops
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(~sw_keep & ~hw_set & ~sw_set)) == '0));

  // R3: no pending bit rises without a set request
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hw_set | sw_set)) == '0));
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] blk_q,
  output logic               edge_mode,
  output logic [NUM_SRC-1:0] sw_set,
  output logic [NUM_SRC-1:0] sw_keep,
  output logic [NUM_SRC-1:0] bus_rdata
);
  reg_sel_e           sel;
  logic               edge_q;
  logic               msg_q;
  logic               wr;
  logic               rd;
  logic [NUM_SRC-1:0] ctl_view;
  logic [NUM_SRC-1:0] rd_d;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_PEND)) sel = SEL_PEND;
    else if (bus_addr == ADDR_W'(OFF_INJ))  sel = SEL_INJ;
    else if (bus_addr == ADDR_W'(OFF_BLK))  sel = SEL_BLK;
    else if (bus_addr == ADDR_W'(OFF_CTL))  sel = SEL_CTL;
    else                                    sel = SEL_NONE;
  end

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  assign sw_keep = (wr && sel == SEL_PEND) ? bus_wdata : '1;
  assign sw_set  = (wr && sel == SEL_INJ)  ? bus_wdata : '0;

  always_comb begin
    ctl_view               = '0;
    ctl_view[CTL_EDGE_BIT] = edge_q;
    ctl_view[CTL_MSG_BIT]  = msg_q;
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_d = pend_q;
      SEL_BLK:  rd_d = blk_q;
      SEL_CTL:  rd_d = ctl_view;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q     <= '1;
      edge_q    <= 1'b0;
      msg_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr && sel == SEL_BLK) blk_q <= bus_wdata;
      if (wr && sel == SEL_CTL) begin
        edge_q <= bus_wdata[CTL_EDGE_BIT];
        msg_q  <= bus_wdata[CTL_MSG_BIT];
      end
      if (rd) bus_rdata <= rd_d;
    end
  end

  assign edge_mode = edge_q;

  // R6: a mask write is visible on the next cycle
  p_blk_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_BLK) |=> (blk_q == $past(bus_wdata)));

  // R8: a pending read returns raw pending bits
  p_pend_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_PEND) |=> (bus_rdata == $past(pend_q)));

  // R11: read data holds while no read is strobed
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: rtl/irq_wire_agg.sv
module irq_wire_agg #(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] sw_set;
  logic [NUM_SRC-1:0] sw_keep;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] blk_q;
  logic               edge_mode;

  irq_src_front #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .src_i(src_i), .edge_mode(edge_mode), .hw_set_o(hw_set)
  );

  irq_cause_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .hw_set(hw_set), .sw_set(sw_set),
    .sw_keep(sw_keep), .pend_q(pend_q)
  );

  irq_csr #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .blk_q(blk_q), .edge_mode(edge_mode), .sw_set(sw_set),
    .sw_keep(sw_keep), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend_q & ~blk_q);
  end

  // R7: output follows pending-and-unmasked one cycle later
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|($past(pend_q) & ~$past(blk_q)))));
endmodule

// File: tb/irq_wire_agg_tb.sv
`timescale 1ns/1ps
module irq_wire_agg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_wire_agg u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[5:0];
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(5);
    rst = 1'b0;

    // R1 reset state, R11 unmapped and inject readback
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(8'h00, v); chk("R1 pending", v, 32'h0);
    rd(8'h10, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R1 control", v, 32'h0);
    rd(8'h08, v); chk("R5 inject reads zero", v, 32'h0);
    rd(8'h04, v); chk("R11 unmapped", v, 32'h0);
    rd(8'h3C, v); chk("R11 unmapped", v, 32'h0);

    // Level mode sweep: R2, R4, R6, R7, R8
    for (int i = 0; i < 32; i++) begin
      src_i = 32'h1 << i;
      idle(4);
      rd(8'h00, v); chk("R8 raw pending while masked", v, 32'h1 << i);
      chk("R6 all masked", {31'b0, irq_o}, 32'h0);
      wr(8'h00, 32'h0);
      rd(8'h00, v); chk("R2 clear while high", v, 32'h1 << i);
      wr(8'h10, ~(32'h1 << ((i + 1) % 32)));
      @(negedge clk); chk("R6 other line open", {31'b0, irq_o}, 32'h0);
      wr(8'h10, ~(32'h1 << i));
      @(negedge clk); chk("R7 line open", {31'b0, irq_o}, 32'h1);
      rd(8'h10, v); chk("R6 mask readback", v, ~(32'h1 << i));
      wr(8'h10, 32'hFFFF_FFFF);
      src_i = '0;
      idle(4);
      wr(8'h00, 32'h0);
      rd(8'h00, v); chk("R4 clear after drop", v, 32'h0);
    end

    // R5 inject, R4 partial clear
    wr(8'h08, 32'hA5A5_A5A5);
    rd(8'h00, v); chk("R5 inject", v, 32'hA5A5_A5A5);
    wr(8'h08, 32'h0);
    rd(8'h00, v); chk("R5 zero inject no effect", v, 32'hA5A5_A5A5);
    wr(8'h00, 32'hFFFF_00FF);
    rd(8'h00, v); chk("R4 partial clear", v, 32'hA5A5_00A5);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R4 ones keep", v, 32'hA5A5_00A5);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R4 clear all", v, 32'h0);

    // R7 latency: one cycle after pending changes
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h08, 32'h1);
    chk("R7 not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk); chk("R7 one cycle later", {31'b0, irq_o}, 32'h1);
    wr(8'h00, 32'h0);
    chk("R7 still high", {31'b0, irq_o}, 32'h1);
    @(negedge clk); chk("R7 drops", {31'b0, irq_o}, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);

    // R9 control word
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R9 only two bits", v, 32'h0000_0028);
    wr(8'h28, 32'h0000_0008);
    rd(8'h28, v); chk("R9 edge only", v, 32'h0000_0008);
    wr(8'h28, 32'h0000_0028);

    // Edge mode sweep: R3
    for (int i = 0; i < 32; i++) begin
      src_i = 32'h1 << i;
      idle(4);
      rd(8'h00, v); chk("R3 rising edge captured", v, 32'h1 << i);
      wr(8'h00, 32'h0);
      idle(2);
      rd(8'h00, v); chk("R3 steady high no reset", v, 32'h0);
      src_i = '0;
      idle(4);
      src_i = 32'h1 << i;
      idle(1);
      src_i = '0;
      idle(4);
      rd(8'h00, v); chk("R3 short pulse latched", v, 32'h1 << i);
      wr(8'h00, 32'h0);
    end

    // R9 message flag has no effect on output
    wr(8'h10, 32'hFFFF_FF7F);
    wr(8'h08, 32'h80);
    @(negedge clk); chk("R9 flag no effect", {31'b0, irq_o}, 32'h1);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);

    // R10 rising edge collides with a software clear
    idle(4);
    @(negedge clk); src_i = 32'h0000_0400;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h0;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(8'h00, v); chk("R10 set wins", v, 32'h0000_0400);
    src_i = '0;
    idle(4);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R10 cleared afterward", v, 32'h0);

    // R2 level mode again after switching back
    wr(8'h28, 32'h0);
    src_i = 32'h8000_0000;
    idle(4);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R2 level re-sets", v, 32'h8000_0000);
    src_i = '0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule